// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command pins of one 16-bit SDR SDRAM device from reset through its required start-up sequence. After a power-up hold of no-operation cycles, it issues an all-bank precharge, then two auto-refresh commands, then a mode-register load that puts a configuration word on the address bus. Each spacing between commands is set at elaboration time. The spacing is a minimum time in nanoseconds, converted into clock cycles from the clock frequency parameter.

When the final mode-register delay has passed, `init_done` rises and stays high. The command pins then idle at no-operation, so a normal access engine can take over the device. The two byte-lane mask outputs keep the data bus masked for the whole sequence. After the sequence, they follow a per-byte enable request: a lane that is not enabled is masked. All pins are plain control and status signals. No data stream passes through the block, so it has no handshake. A synchronous reset restarts the whole sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, and for N_PWR cycles after it is released, the command pins hold no-operation and `init_done` is low. N_PWR is the power-up time converted to cycles.
- R2: The first command after reset is a precharge with address bit 10 high, so that all banks close together. It appears N_PWR cycles after reset is released.
- R3: A time of t ns becomes ceil(t × f_MHz / 1000) cycles, and never fewer than 1. For example, 63 ns at 100 MHz gives 7 cycles and 20 ns gives 2.
- R4: Commands are coded on {CS#, RAS#, CAS#, WE#} as follows: no-operation 0111, precharge 0010, auto-refresh 0001, load-mode 0000. The first auto-refresh comes N_RP cycles after the precharge.
- R5: The second auto-refresh comes N_RFC cycles after the first.
- R6: The load-mode command comes N_RFC cycles after the second auto-refresh. It carries the mode word on `addr`, and `ba` is zero.
- R7: `init_done` rises exactly MRD_CYC cycles after the load-mode command, and it stays high until reset.
- R8: Every cycle that is not one of the four sequence commands is no-operation, including every cycle after `init_done`.
- R9: While `init_done` is low, both `dqm` bits are 1. Once it is high, `dqm[0]` (the low byte, data bits 7:0) equals the inverse of `byte_en[0]`, and `dqm[1]` (the high byte, data bits 15:8) equals the inverse of `byte_en[1]`.
- R10: Asserting `rst` partway through the sequence discards the progress made so far. The sequence starts again from the power-up hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the same as the SDRAM clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_en | input | 2 | Per-byte write enable request (bit 0 is the low byte) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| dqm | output | 2 | Byte-lane masks, 1 = masked |
| init_done | output | 1 | High once initialization is complete |

## Verification
The assertions assume that `rst` is sampled synchronously. They also assume that the clock really runs at `CLK_MHZ`, so that the cycle minimums correspond to the intended times. `byte_en` may take any value at any time. The checks only assume that it has no effect until the sequence ends. The bench changes `rst` and `byte_en` only on falling edges and samples the outputs on falling edges. It holds reset for several whole cycles, and it asserts reset partway through the sequence only at a cycle boundary.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_LMR = 4'b0000
  } cmd_t;

  typedef enum logic [3:0] {
    S_PWR, S_PRE, S_W_RP, S_REF1, S_W_RF1,
    S_REF2, S_W_RF2, S_LMR, S_W_MRD, S_DONE
  } seq_t;

  // Round a nanosecond minimum up to whole cycles, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned f_mhz);
    longint unsigned prod;
    prod = (longint'(t_ns) * longint'(f_mhz) + 64'd999) / 64'd1000;
    if (prod < 1) prod = 1;
    return int'(prod);
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int unsigned N_PWR = 10000,
  parameter int unsigned N_RP  = 2,
  parameter int unsigned N_RFC = 7,
  parameter int unsigned N_MRD = 1
) (
  input  logic clk,
  input  logic rst,
  output cmd_t cmd,
  output logic done
);
  localparam int unsigned N_A   = (N_PWR > N_RFC) ? N_PWR : N_RFC;
  localparam int unsigned N_B   = (N_RP > N_MRD) ? N_RP : N_MRD;
  localparam int unsigned N_MAX = (N_A > N_B) ? N_A : N_B;
  localparam int unsigned CNT_W = $clog2(N_MAX) + 1;

  // Preload for a wait state that covers the N-1 cycles after a command.
  localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(N_PWR - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'((N_RP  > 1) ? N_RP  - 2 : 0);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'((N_RFC > 1) ? N_RFC - 2 : 0);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'((N_MRD > 1) ? N_MRD - 2 : 0);

  seq_t             state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_PWR;
      cnt   <= LD_PWR;
    end else begin
      unique case (state)
        S_PWR:   if (cnt_zero) state <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE:   if (N_RP > 1) begin state <= S_W_RP; cnt <= LD_RP; end
                 else state <= S_REF1;
        S_W_RP:  if (cnt_zero) state <= S_REF1; else cnt <= cnt - 1'b1;
        S_REF1:  if (N_RFC > 1) begin state <= S_W_RF1; cnt <= LD_RFC; end
                 else state <= S_REF2;
        S_W_RF1: if (cnt_zero) state <= S_REF2; else cnt <= cnt - 1'b1;
        S_REF2:  if (N_RFC > 1) begin state <= S_W_RF2; cnt <= LD_RFC; end
                 else state <= S_LMR;
        S_W_RF2: if (cnt_zero) state <= S_LMR; else cnt <= cnt - 1'b1;
        S_LMR:   if (N_MRD > 1) begin state <= S_W_MRD; cnt <= LD_MRD; end
                 else state <= S_DONE;
        S_W_MRD: if (cnt_zero) state <= S_DONE; else cnt <= cnt - 1'b1;
        S_DONE:  state <= S_DONE;
        default: state <= S_PWR;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      S_PRE:         cmd = CMD_PRE;
      S_REF1, S_REF2: cmd = CMD_REF;
      S_LMR:         cmd = CMD_LMR;
      default:       cmd = CMD_NOP;
    endcase
  end

  assign done = (state == S_DONE);

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  cmd_t              cmd,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba = '0;

  always_comb begin
    unique case (cmd)
      CMD_PRE: addr = ALL_BANKS;
      CMD_LMR: addr = MODE_WORD;
      default: addr = '0;
    endcase
  end

endmodule

// File: rtl/sdram_dqm_gate.sv
module sdram_dqm_gate #(
  parameter int unsigned LANES = 2
) (
  input  logic             done,
  input  logic [LANES-1:0] byte_en,
  output logic [LANES-1:0] dqm
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dqm[g] = ~(done & byte_en[g]);
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned T_PWR_NS  = 100000,
  parameter int unsigned T_RP_NS   = 20,
  parameter int unsigned T_RFC_NS  = 63,
  parameter int unsigned MRD_CYC   = 1,
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned BA_W      = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h030
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        byte_en,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic [1:0]        dqm,
  output logic              init_done
);
  localparam int unsigned N_PWR = ns_to_cyc(T_PWR_NS, CLK_MHZ);
  localparam int unsigned N_RP  = ns_to_cyc(T_RP_NS, CLK_MHZ);
  localparam int unsigned N_RFC = ns_to_cyc(T_RFC_NS, CLK_MHZ);
  localparam int unsigned N_MRD = (MRD_CYC < 1) ? 1 : MRD_CYC;

  cmd_t cmd;

  sdram_init_ctrl #(
    .N_PWR(N_PWR), .N_RP(N_RP), .N_RFC(N_RFC), .N_MRD(N_MRD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd(cmd), .done(init_done)
  );

  sdram_cmd_drive #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)
  ) u_drive (
    .cmd(cmd), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba)
  );

  sdram_dqm_gate #(.LANES(2)) u_dqm (
    .done(init_done), .byte_en(byte_en), .dqm(dqm)
  );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned N_RP   = 2,
  parameter int unsigned N_RFC  = 7,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic [1:0]        dqm,
  input logic              init_done
);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  logic [3:0]  pins;
  logic [3:0]  last;
  logic [15:0] gap;
  logic        seen;

  assign pins = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      last <= C_NOP;
      gap  <= '0;
      seen <= 1'b0;
    end else if (pins != C_NOP) begin
      last <= pins;
      gap  <= 16'd1;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap  <= gap + 16'd1;
    end
  end

  AST_FIRST_IS_PRE: assert property (@(posedge clk) disable iff (rst)
    (!seen && pins != C_NOP) |-> pins == C_PRE);                  // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    (pins == C_PRE) |-> addr[10]);                                // R2
  AST_RP_SPACING: assert property (@(posedge clk) disable iff (rst)
    (pins != C_NOP && last == C_PRE) |-> gap >= 16'(N_RP));       // R4
  AST_RFC_SPACING: assert property (@(posedge clk) disable iff (rst)
    (pins != C_NOP && last == C_REF) |-> gap >= 16'(N_RFC));      // R5
  AST_LMR_WORD: assert property (@(posedge clk) disable iff (rst)
    (pins == C_LMR) |-> (addr == MODE_WORD && ba == '0));         // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);                                     // R7
  AST_DONE_AFTER_LMR: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> last == C_LMR);                          // R7
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    init_done |-> pins == C_NOP);                                 // R8
  AST_DQM_HELD: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> dqm == 2'b11);                                 // R9

endmodule

bind sdram_init_seq sdram_init_chk #(
  .N_RP(N_RP), .N_RFC(N_RFC), .ADDR_W(ADDR_W), .BA_W(BA_W),
  .MODE_WORD(MODE_WORD)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .ba(ba), .dqm(dqm), .init_done(init_done)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ     = 100;
  localparam int PWR_NS  = 200;
  localparam int RP_NS   = 20;
  localparam int RFC_NS  = 63;
  localparam int MRD     = 2;
  localparam int AW      = 13;
  localparam logic [AW-1:0] MODE = 13'h027;

  // R3: independent ceiling conversion
  function automatic int cyc_of(input int ns);
    int v;
    v = (ns * MHZ + 999) / 1000;
    return (v < 1) ? 1 : v;
  endfunction

  localparam int E_PWR = (PWR_NS * MHZ + 999) / 1000;
  localparam int E_RP  = (RP_NS * MHZ + 999) / 1000;
  localparam int E_RFC = (RFC_NS * MHZ + 999) / 1000;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] EXP_CMD [4] = '{4'b0010, 4'b0001, 4'b0001, 4'b0000};
  localparam int         EXP_GAP [4] = '{E_PWR, E_RP, E_RFC, E_RFC};
  localparam logic [1:0] BE_PAT  [4] = '{2'b00, 2'b01, 2'b10, 2'b11};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] byte_en = 2'b00;
  logic cs_n, ras_n, cas_n, we_n, init_done;
  logic [AW-1:0] addr;
  logic [1:0] ba, dqm;
  logic [3:0] pins;
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  assign pins = {cs_n, ras_n, cas_n, we_n};

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  sdram_init_seq #(
    .CLK_MHZ(MHZ), .T_PWR_NS(PWR_NS), .T_RP_NS(RP_NS), .T_RFC_NS(RFC_NS),
    .MRD_CYC(MRD), .ADDR_W(AW), .BA_W(2), .MODE_WORD(MODE)
  ) dut (
    .clk(clk), .rst(rst), .byte_en(byte_en), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .dqm(dqm),
    .init_done(init_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Step falling edges until a non-NOP command shows; return its cycle.
  task automatic wait_cmd(output int at);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (pins == NOP && guard < 5000);
    at = cyc;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t_prev, t_now;

    // R1, R9: reset state
    byte_en = 2'b11;
    repeat (3) @(negedge clk);
    check(pins == NOP, "R1", "cmd in reset", pins, NOP);
    check(init_done == 1'b0, "R1", "done in reset", init_done, 0);
    check(dqm == 2'b11, "R9", "dqm in reset", dqm, 3);
    check(E_RFC == cyc_of(RFC_NS) && E_RFC == 7 && E_RP == 2, "R3",
          "conversion", E_RFC, 7);
    rst = 1'b0;

    // Table walk: R2, R4, R5, R6 (and R1, R8 via gap)
    t_prev = 0;
    for (int i = 0; i < 4; i++) begin
      wait_cmd(t_now);
      check(pins == EXP_CMD[i], "R4", "command code", pins, EXP_CMD[i]);
      check(t_now - t_prev == EXP_GAP[i], (i == 0) ? "R2" : (i == 1) ? "R4" : "R5",
            "spacing", t_now - t_prev, EXP_GAP[i]);
      check(init_done == 1'b0 && dqm == 2'b11, "R9", "mask during init",
            {init_done, dqm}, 3);
      if (i == 0) check(addr[10] == 1'b1, "R2", "A10 on precharge", addr, 1 << 10);
      if (i == 3) check(addr == MODE && ba == 2'b00, "R6", "mode word",
                        addr, MODE);
      t_prev = t_now;
    end

    // R7: done timing
    for (int k = 1; k < MRD; k++) begin
      @(negedge clk);
      check(init_done == 1'b0 && pins == NOP, "R7", "early done",
            init_done, 0);
    end
    @(negedge clk);
    check(init_done == 1'b1, "R7", "done rise", init_done, 1);
    check(cyc - t_prev == MRD, "R7", "done delay", cyc - t_prev, MRD);

    // R8, R7: idle and sticky after done
    begin
      bit ok = 1'b1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (pins != NOP || !init_done) ok = 1'b0;
      end
      check(ok, "R8", "idle NOP after done", pins, NOP);
    end

    // R9: lane masks after done
    for (int i = 0; i < 4; i++) begin
      byte_en = BE_PAT[i];
      #1;
      check(dqm == ~BE_PAT[i], "R9", "dqm lanes", dqm, ~BE_PAT[i]);
    end

    // R10: reset partway through restarts the sequence
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(init_done == 1'b0, "R10", "done cleared", init_done, 0);
    rst = 1'b0;
    wait_cmd(t_now);           // precharge
    wait_cmd(t_now);           // first refresh
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wait_cmd(t_now);
    check(pins == EXP_CMD[0] && t_now == E_PWR, "R10", "restart at precharge",
          t_now, E_PWR);

    finish_run();
  end

endmodule